// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block combines four reset sources into one internal reset for the rest of the chip. It also keeps a sticky record of which source caused the last reset. The four sources are:

- power-on, delivered on the asynchronous `rst_ni`;
- a qualified low level on the external reset pin;
- a software write that clears a reset-request bit;
- a watchdog overflow pulse.

The sources differ in whether an oscillation-stabilization wait comes before release:

- Power-on waits a fixed number of oscillation ticks.
- Watchdog waits a length picked by a two-bit select.
- The pin and software releases carry no wait.

The pin input passes through a synchronizer and a minimum-low-width filter, so short glitches are ignored. A pin reset that arrives while the CPU reports a write transfer in flight is held back until the transfer ends. The software and watchdog sources are never held back this way.

Oscillation-clock cycles are presented to the block as a one-cycle strobe `osc_tick_i` in the machine-clock domain. All wait lengths count these strobes, not machine cycles. Wait lengths are powers of two given as exponent parameters.

Top module: `rst_seq_top`

## Requirements
- R1: After its two-flop synchronizer, the pin must read low for PIN_MIN_LOW (default 16) consecutive machine cycles before it counts as a reset request; shorter low pulses leave `sys_rst_o` deasserted.
- R2: A pin reset asserts `sys_rst_o` and keeps it asserted while the synchronized pin stays low. It releases with no stabilization wait (`osc_wait_o` stays 0). A pin held low for N ≥ 16 cycles gives N−15 asserted cycles.
- R3: A software write (`sw_wr_i`=1) with `sw_bit_i`=0 asserts `sys_rst_o` for exactly one cycle with no wait. A write with `sw_bit_i`=1 has no effect.
- R4: A watchdog overflow asserts `sys_rst_o` for one cycle and then for 2^WD_LOGk oscillation ticks, during which `osc_wait_o` is high. k is the value of `wd_sel_i` when the overflow is taken: 0 selects WD_LOG0 (default 10), 1 selects WD_LOG1 (13), 2 selects WD_LOG2 (15), and 3 selects WD_LOG3 (17).
- R5: While `rst_ni` is low, and afterwards until 2^POR_LOG (default 2^18) oscillation ticks have been counted, `sys_rst_o` and `osc_wait_o` are both high.
- R6: While `cpu_busy_i` is high, a qualified pin request does not assert reset. It is remembered, even if the pin returns high, and is taken in the first cycle `cpu_busy_i` is low. Software and watchdog requests are not deferred.
- R7: `cause_o` bits are [0] power-on, [1] watchdog, [2] pin, [3] software. Power-on sets the value to 4'b0001. Each accepted reset sets its bit, and bits already set stay set. A `cause_clr_i` pulse clears all bits to 0.
- R8: When requests coincide, the watchdog beats the pin, and the pin beats software. Only the winner's cause bit is set and only the winner's wait is applied. A deferred pin request that lost to the watchdog is dropped.
- R9: The stabilization wait advances only in cycles where `osc_tick_i` is high, and ends on the 2^L-th tick.
- R10: Software and watchdog requests that arrive while `sys_rst_o` is asserted are ignored: they neither lengthen the reset nor set cause bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Machine clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| osc_tick_i | input | 1 | One-cycle strobe per oscillation-clock cycle |
| ext_rst_ni | input | 1 | Raw external reset pin, active low |
| sw_wr_i | input | 1 | Software write strobe to the reset-request bit |
| sw_bit_i | input | 1 | Value written; 0 requests reset |
| wdt_ovf_i | input | 1 | Watchdog overflow pulse |
| wd_sel_i | input | 2 | Watchdog stabilization-wait select |
| cpu_busy_i | input | 1 | CPU write transfer in progress |
| cause_clr_i | input | 1 | Clears all cause flags |
| sys_rst_o | output | 1 | Internal reset, active high |
| osc_wait_o | output | 1 | Stabilization wait in progress |
| cause_o | output | 4 | Sticky reset-cause flags |

## Verification
The cycle timing of each result is fixed:

- A software or watchdog request driven before edge e raises `sys_rst_o` right after e. The reset then lasts 1 cycle for software and 1+2^L cycles for the watchdog when ticks are continuous.
- A pin low for N cycles first resets after synchronizer latency plus the 16-cycle filter, and releases two edges after the pin rises. This gives N−15 asserted cycles.
- After `rst_ni` rises, the power-on reset lasts 2^POR_LOG−1 further cycles.

The bench drives all inputs and samples all outputs on the falling clock edge. It counts asserted and waiting cycles between those samples and compares the totals with these formulas. With random tick patterns, it counts only the ticks offered while `osc_wait_o` is high.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_ASSERT, ST_WAIT} seq_state_e;
  // values double as cause bit indices
  typedef enum logic [1:0] {SRC_POR, SRC_WDT, SRC_EXT, SRC_SW} rst_src_e;
  localparam int CAUSE_W = 4;
endpackage

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
  parameter int MIN_LOW     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic pin_low_o,
  output logic qual_o
);
  localparam int CNT_W = $clog2(MIN_LOW + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_ni};
  end

  assign pin_low_o = ~sync_q[SYNC_STAGES-1];

  // saturating count of consecutive low cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (!pin_low_o)                  cnt_q <= '0;
    else if (cnt_q != CNT_W'(MIN_LOW - 1)) cnt_q <= cnt_q + 1'b1;
  end

  assign qual_o = pin_low_o && (cnt_q == CNT_W'(MIN_LOW - 1));

  AST_QUAL_AFTER_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(qual_o) |-> $past(pin_low_o)); // R1
endmodule

// File: rtl/rst_arbiter.sv
module rst_arbiter
  import rst_seq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     idle_i,
  input  logic     pin_qual_i,
  input  logic     cpu_busy_i,
  input  logic     sw_wr_i,
  input  logic     sw_bit_i,
  input  logic     wdt_ovf_i,
  output logic     req_o,
  output rst_src_e src_o
);
  logic pend_q;
  logic ext_rdy, sw_req;

  assign ext_rdy = (pin_qual_i | pend_q) & ~cpu_busy_i;
  assign sw_req  = sw_wr_i & ~sw_bit_i;

  always_comb begin
    req_o = 1'b0;
    src_o = SRC_SW;
    if (idle_i) begin
      if (wdt_ovf_i) begin
        req_o = 1'b1;
        src_o = SRC_WDT;
      end else if (ext_rdy) begin
        req_o = 1'b1;
        src_o = SRC_EXT;
      end else if (sw_req) begin
        req_o = 1'b1;
        src_o = SRC_SW;
      end
    end
  end

  // remembers a pin request deferred by a busy CPU
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   pend_q <= 1'b0;
    else if (!idle_i || (req_o && src_o == SRC_EXT)) pend_q <= 1'b0;
    else if (pin_qual_i)                           pend_q <= 1'b1;
  end

  AST_DEFER_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && pin_qual_i && cpu_busy_i && !wdt_ovf_i && !sw_req) |=> pend_q); // R6
endmodule

// File: rtl/rst_wait_timer.sv
module rst_wait_timer #(
  parameter int MAX_LOG  = 18,
  parameter int INIT_LOG = 18,
  localparam int LOG_W   = $clog2(MAX_LOG + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LOG_W-1:0] log_i,
  input  logic             run_i,
  input  logic             tick_i,
  output logic             done_o
);
  localparam int CNT_W = MAX_LOG;

  logic [LOG_W-1:0] log_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  assign lim    = ~({CNT_W{1'b1}} << log_q);
  assign done_o = run_i && tick_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      log_q <= LOG_W'(INIT_LOG);
      cnt_q <= '0;
    end else if (load_i) begin
      log_q <= log_i;
      cnt_q <= '0;
    end else if (run_i && tick_i) begin
      cnt_q <= done_o ? '0 : cnt_q + 1'b1;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim); // R4
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
  import rst_seq_pkg::*;
#(
  parameter int POR_LOG     = 18,
  parameter int WD_LOG0     = 10,
  parameter int WD_LOG1     = 13,
  parameter int WD_LOG2     = 15,
  parameter int WD_LOG3     = 17,
  parameter int PIN_MIN_LOW = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               osc_tick_i,
  input  logic               ext_rst_ni,
  input  logic               sw_wr_i,
  input  logic               sw_bit_i,
  input  logic               wdt_ovf_i,
  input  logic [1:0]         wd_sel_i,
  input  logic               cpu_busy_i,
  input  logic               cause_clr_i,
  output logic               sys_rst_o,
  output logic               osc_wait_o,
  output logic [CAUSE_W-1:0] cause_o
);
  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_LOG = max2(max2(POR_LOG, max2(WD_LOG0, WD_LOG1)), max2(WD_LOG2, WD_LOG3));
  localparam int LOG_W   = $clog2(MAX_LOG + 1);

  seq_state_e         state_q, state_d;
  rst_src_e           src_q, req_src;
  logic               req, pin_low, pin_qual, timer_done, timer_load;
  logic [LOG_W-1:0]   wd_log;
  logic [CAUSE_W-1:0] cause_q, cause_d;

  rst_pin_filter #(
    .MIN_LOW    (PIN_MIN_LOW),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_pin (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_ni   (ext_rst_ni),
    .pin_low_o(pin_low),
    .qual_o   (pin_qual)
  );

  rst_arbiter u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idle_i    (state_q == ST_RUN),
    .pin_qual_i(pin_qual),
    .cpu_busy_i(cpu_busy_i),
    .sw_wr_i   (sw_wr_i),
    .sw_bit_i  (sw_bit_i),
    .wdt_ovf_i (wdt_ovf_i),
    .req_o     (req),
    .src_o     (req_src)
  );

  always_comb begin
    unique case (wd_sel_i)
      2'd0:    wd_log = LOG_W'(WD_LOG0);
      2'd1:    wd_log = LOG_W'(WD_LOG1);
      2'd2:    wd_log = LOG_W'(WD_LOG2);
      default: wd_log = LOG_W'(WD_LOG3);
    endcase
  end

  assign timer_load = (state_q == ST_RUN) && req && (req_src == SRC_WDT);

  rst_wait_timer #(
    .MAX_LOG (MAX_LOG),
    .INIT_LOG(POR_LOG)
  ) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(timer_load),
    .log_i (wd_log),
    .run_i (state_q == ST_WAIT),
    .tick_i(osc_tick_i),
    .done_o(timer_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:    if (req) state_d = ST_ASSERT;
      ST_ASSERT: begin
        if (src_q == SRC_EXT && pin_low) state_d = ST_ASSERT;
        else if (src_q == SRC_WDT)       state_d = ST_WAIT;
        else                             state_d = ST_RUN;
      end
      ST_WAIT:   if (timer_done) state_d = ST_RUN;
      default:   state_d = ST_RUN;
    endcase
  end

  always_comb begin
    cause_d = cause_q;
    if (cause_clr_i) cause_d = '0;
    if (req)         cause_d[req_src] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      src_q   <= SRC_POR;
      cause_q <= CAUSE_W'(1);
    end else begin
      state_q <= state_d;
      cause_q <= cause_d;
      if (req) src_q <= req_src;
    end
  end

  assign sys_rst_o  = (state_q != ST_RUN);
  assign osc_wait_o = (state_q == ST_WAIT);
  assign cause_o    = cause_q;

  AST_WDT_PRIORITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && wdt_ovf_i) |=> (state_q == ST_ASSERT && src_q == SRC_WDT)); // R8
  AST_NO_WAIT_PIN_SW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ASSERT && src_q != SRC_WDT) |=> (state_q != ST_WAIT)); // R2
  AST_PIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ASSERT && src_q == SRC_EXT && pin_low) |=> sys_rst_o); // R2
  AST_BUSY_BLOCKS_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && cpu_busy_i && !wdt_ovf_i && !(sw_wr_i && !sw_bit_i)) |=> (state_q == ST_RUN)); // R6
  AST_CAUSE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cause_clr_i |=> ((cause_q & $past(cause_q)) == $past(cause_q))); // R7
  AST_SRC_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_RUN) |=> $stable(src_q)); // R10
endmodule

// File: tb/rst_seq_top_test.sv
module rst_seq_top_test;
  localparam int POR_LOG = 6;
  localparam int WL0 = 2, WL1 = 3, WL2 = 4, WL3 = 5;
  localparam int MIN_LOW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic ext_n = 1'b1;
  logic sw_wr = 1'b0, sw_bit = 1'b1, wdt = 1'b0;
  logic [1:0] wd_sel = 2'd0;
  logic busy = 1'b0, cclr = 1'b0;
  logic sys_rst, osc_wait;
  logic [3:0] cause;

  int errors = 0;
  int checks = 0;
  int seed_val;

  always #4 clk = ~clk;

  rst_seq_top #(
    .POR_LOG(POR_LOG), .WD_LOG0(WL0), .WD_LOG1(WL1), .WD_LOG2(WL2), .WD_LOG3(WL3),
    .PIN_MIN_LOW(MIN_LOW), .SYNC_STAGES(2)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .osc_tick_i(tick), .ext_rst_ni(ext_n),
    .sw_wr_i(sw_wr), .sw_bit_i(sw_bit), .wdt_ovf_i(wdt), .wd_sel_i(wd_sel),
    .cpu_busy_i(busy), .cause_clr_i(cclr),
    .sys_rst_o(sys_rst), .osc_wait_o(osc_wait), .cause_o(cause)
  );

  function automatic int wd_len(input int sel);
    case (sel)
      0: return 1 << WL0;
      1: return 1 << WL1;
      2: return 1 << WL2;
      default: return 1 << WL3;
    endcase
  endfunction

  function automatic int pin_len(input int n);
    return (n >= MIN_LOW) ? n - (MIN_LOW - 1) : 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(input int limit, output int hi, output int wt);
    bit seen;
    seen = 1'b0;
    hi = 0;
    wt = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (sys_rst) begin hi++; seen = 1'b1; end
      if (osc_wait) wt++;
      if (seen && !sys_rst) break;
    end
  endtask

  task automatic pin_low(input int n);
    ext_n = 1'b0;
    step(n);
    ext_n = 1'b1;
  endtask

  task automatic sw_pulse(input logic v);
    sw_wr = 1'b1; sw_bit = v;
    step(1);
    sw_wr = 1'b0; sw_bit = 1'b1;
  endtask

  task automatic wdt_pulse();
    wdt = 1'b1;
    step(1);
    wdt = 1'b0;
  endtask

  task automatic clr_cause();
    cclr = 1'b1;
    step(1);
    cclr = 1'b0;
  endtask

  // random tick pattern; counts ticks offered while waiting
  task automatic wd_rand(input int sel, output int tcnt, output int hi);
    bit seen;
    seen = 1'b0;
    tcnt = 0;
    hi = 0;
    wd_sel = sel[1:0];
    wdt = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      wdt = 1'b0;
      if (sys_rst) begin hi++; seen = 1'b1; end
      if (seen && !sys_rst) break;
      tick = ($urandom % 3) == 0;
      if (osc_wait && tick) tcnt++;
    end
    tick = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL run-timeout: actual hung expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int hi, wt, tc;
    seed_val = $urandom(32'd20240611);

    // R5 reset state
    step(3);
    chk("R5 rst in reset", int'(sys_rst), 1);
    chk("R5 wait in reset", int'(osc_wait), 1);
    chk("R7 cause after power-on", int'(cause), 4'b0001);
    rst_n = 1'b1;
    measure(500, hi, wt);
    chk("R5 por length", hi, (1 << POR_LOG) - 1);
    chk("R5 por wait length", wt, (1 << POR_LOG) - 1);
    step(3);

    // R3 software
    fork sw_pulse(1'b1); measure(10, hi, wt); join
    chk("R3 write 1 ignored", hi, 0);
    fork sw_pulse(1'b0); measure(10, hi, wt); join
    chk("R3 sw length", hi, 1);
    chk("R3 sw no wait", wt, 0);
    chk("R7 sticky por + sw", int'(cause), 4'b1001);
    clr_cause();
    chk("R7 clear", int'(cause), 0);

    // R1 / R2 pin directed
    fork pin_low(15); measure(40, hi, wt); join
    chk("R1 15-cycle pulse ignored", hi, 0);
    step(4);
    fork pin_low(16); measure(60, hi, wt); join
    chk("R1 16-cycle pulse", hi, 1);
    chk("R2 pin no wait", wt, 0);
    chk("R7 pin cause", int'(cause), 4'b0100);
    step(4);
    fork pin_low(40); measure(80, hi, wt); join
    chk("R2 pin hold length", hi, 25);

    // R1 / R2 random widths
    for (int k = 0; k < 8; k++) begin
      int n;
      n = 5 + int'($urandom % 36);
      step(4);
      fork pin_low(n); measure(80, hi, wt); join
      chk($sformatf("R1 R2 random width %0d", n), hi, pin_len(n));
    end
    step(4);

    // R4 each select, continuous ticks
    for (int s = 0; s < 4; s++) begin
      clr_cause();
      wd_sel = s[1:0];
      fork wdt_pulse(); measure(500, hi, wt); join
      chk($sformatf("R4 wdt sel %0d rst", s), hi, wd_len(s) + 1);
      chk($sformatf("R4 wdt sel %0d wait", s), wt, wd_len(s));
      chk("R7 wdt cause", int'(cause), 4'b0010);
      step(2);
    end

    // R9 random tick density
    for (int k = 0; k < 6; k++) begin
      int s;
      s = int'($urandom % 4);
      wd_rand(s, tc, hi);
      chk($sformatf("R9 ticks sel %0d", s), tc, wd_len(s));
      step(2);
    end

    // R6 deferral
    clr_cause();
    busy = 1'b1;
    fork pin_low(20); measure(30, hi, wt); join
    chk("R6 pin deferred while busy", hi, 0);
    busy = 1'b0;
    measure(10, hi, wt);
    chk("R6 deferred pin taken", hi, 1);
    chk("R6 deferred cause", int'(cause), 4'b0100);
    step(3);
    busy = 1'b1;
    fork sw_pulse(1'b0); measure(10, hi, wt); join
    chk("R6 sw not deferred", hi, 1);
    busy = 1'b0;
    step(3);

    // R8 pin beats sw
    clr_cause();
    busy = 1'b1;
    pin_low(20);
    step(10);
    busy = 1'b0;
    fork sw_pulse(1'b0); measure(10, hi, wt); join
    chk("R8 pin over sw cause", int'(cause), 4'b0100);
    step(3);

    // R8 wdt beats pin, pending pin dropped
    clr_cause();
    busy = 1'b1;
    pin_low(20);
    step(10);
    busy = 1'b0;
    wd_sel = 2'd0;
    fork wdt_pulse(); measure(200, hi, wt); join
    chk("R8 wdt over pin cause", int'(cause), 4'b0010);
    chk("R8 wdt wait applied", hi, wd_len(0) + 1);
    measure(10, hi, wt);
    chk("R8 lost pin dropped", hi, 0);

    // R10 requests during reset ignored
    clr_cause();
    wd_sel = 2'd3;
    fork
      measure(500, hi, wt);
      begin
        wdt_pulse();
        step(5);
        sw_wr = 1'b1; sw_bit = 1'b0; wdt = 1'b1;
        step(1);
        sw_wr = 1'b0; sw_bit = 1'b1; wdt = 1'b0;
      end
    join
    chk("R10 length unchanged", hi, wd_len(3) + 1);
    chk("R10 cause unchanged", int'(cause), 4'b0010);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule